// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a host a small window of 256 byte-wide configuration registers through just two byte-wide I/O port addresses. The host first writes a register number to the lower (index) port. It then reads or writes the chosen register through the upper (data) port. The index stays put between data accesses, so the same register can be read or written many times without selecting it again.

Writes through the data port are filtered per register. Most register numbers are read-only and silently drop writes. A handful are freely writable. Two are locked to a single legal value and drop any other value. A fixed set of registers comes out of reset with non-zero defaults.

The whole window sits behind an enable bit that lives in a byte of an external bridge's configuration space. The window is closed after reset. While it is closed, the block ignores every port access and a read gives all ones.

Top module: `cfg_window`

## Requirements
- R1: After reset the window is closed, the index is 0x00, and a read at either port returns 0xFF.
- R2: A bridge configuration write to offset 0x85 sets the window open when bit 1 of its data is 1 and closes it when bit 1 is 0; the other data bits and writes to any other bridge offset leave the window state unchanged.
- R3: With the window open, a write to the index port (I/O address 0x3F0) makes its data byte the current index, which selects the register seen at the data port from the next cycle on.
- R4: With the window open, a data-port write (I/O address 0x3F1) to a writable index stores the byte, and a later read at either port returns it; the writable indices are 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R5: A data-port write to any of the indices 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF leaves the register unchanged.
- R6: Index 0xE7 stores a data-port write only when the byte is 0xFE, and index 0xE8 only when the byte is 0xBE; any other value leaves them unchanged.
- R7: A read changes neither the index nor any register; repeated reads and repeated data writes use the same index until the index port is written.
- R8: While the window is closed, port writes change neither the index nor any register, and every read returns 0xFF.
- R9: Reset loads 0x3C into 0xE0, 0x03 into 0xE2, 0xFC into 0xE3, 0xDE into 0xE6, 0xFE into 0xE7 and 0xBE into 0xE8; every other register resets to 0x00.
- R10: Accesses at I/O addresses other than 0x3F0 and 0x3F1 change no state, and a read there returns 0xFF; io_rdata is also 0xFF whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bridge_wr_en | input | 1 | Write strobe into the bridge configuration space |
| bridge_wr_addr | input | 8 | Bridge configuration byte offset being written |
| bridge_wr_data | input | 8 | Bridge configuration byte being written |
| io_wr | input | 1 | One-byte I/O write strobe |
| io_rd | input | 1 | One-byte I/O read strobe |
| io_addr | input | 16 | I/O port address of the access |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte, combinational from the current state |

## Verification
On every cycle the assertions check that a closed window returns 0xFF and holds its index, that an index write lands exactly, that reads disturb neither the index nor the selected byte, that protected and value-locked indices keep their byte after a rejected write, and that the bridge byte at offset 0x85 drives the enable. The exact reset defaults, the full writable and read-only maps, the visibility of a stored byte through a later read, and the reopening of the window with its earlier state intact are shown only by the bench's directed scenarios, which compare read data against values worked out from the requirements.

// File: rtl/cfgw_pkg.sv
// Package cfgw_pkg
// Shared widths and the per-index policy of the configuration window:
// which indices accept writes, which accept only one value, and the
// reset default of each index. Assumes an 8-bit index space.
package cfgw_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 8;
    localparam int NUM_REGS = 1 << IDX_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // True when an index may be written at all (value locks applied separately).
    function automatic logic idx_open(input idx_t idx);
        logic ok;
        case (idx) inside
            8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6: ok = 1'b1;
            8'hE7, 8'hE8:                      ok = 1'b1;
            [8'hEE:8'hF2]:                     ok = 1'b1;
            8'hF4, 8'hF6, 8'hF8, 8'hFC:        ok = 1'b1;
            default:                           ok = 1'b0;
        endcase
        return ok;
    endfunction

    // True when an index accepts only a single fixed value.
    function automatic logic idx_locked(input idx_t idx);
        return (idx == 8'hE7) || (idx == 8'hE8);
    endfunction

    // The only value a locked index accepts.
    function automatic byte_t lock_value(input idx_t idx);
        return (idx == 8'hE7) ? 8'hFE : 8'hBE;
    endfunction

    // Reset default of each index.
    function automatic byte_t reset_byte(input idx_t idx);
        byte_t v;
        case (idx)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            8'hE6:   v = 8'hDE;
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfgw_enable_gate.sv
// Module cfgw_enable_gate
// Holds the window enable flag. It watches byte writes into the external
// bridge configuration space and copies one bit of the byte written to one
// offset. Assumes at most one bridge byte write per cycle.
module cfgw_enable_gate #(
    parameter int          OFS_W   = 8,
    parameter logic [7:0]  EN_OFS  = 8'h85,
    parameter int          EN_BIT  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [OFS_W-1:0]         wr_addr,
    input  logic [cfgw_pkg::BYTE_W-1:0] wr_data,
    output logic                     win_en
);
    localparam logic [OFS_W-1:0] MATCH_OFS = OFS_W'(EN_OFS);

    logic hit;
    logic unused_bridge_bits;

    // Detect a write to the enable offset.
    always_comb hit = wr_en && (wr_addr == MATCH_OFS);

    // Other bits of the byte are not this block's concern.
    assign unused_bridge_bits = ^wr_data;

    // Track the enable bit; closed after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en <= 1'b0;
        end else if (hit) begin
            win_en <= wr_data[EN_BIT];
        end
    end

endmodule

// File: rtl/cfgw_port_decode.sv
// Module cfgw_port_decode
// Decodes one-byte I/O accesses against the two-port window and keeps the
// current index. Assumes the base address is even so that the index port
// and data port differ only in bit 0. Nothing is decoded while closed.
module cfgw_port_decode #(
    parameter int                ADDR_W  = 16,
    parameter logic [15:0]       IO_BASE = 16'h03F0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_en,
    input  logic                        io_wr,
    input  logic                        io_rd,
    input  logic [ADDR_W-1:0]           io_addr,
    input  logic [cfgw_pkg::BYTE_W-1:0] io_wdata,
    output logic [cfgw_pkg::IDX_W-1:0]  cur_idx,
    output logic                        data_wr,
    output logic                        rd_hit
);
    localparam logic [ADDR_W-1:0] INDEX_ADDR = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] DATA_ADDR  = ADDR_W'(IO_BASE) + ADDR_W'(1);

    logic at_index;
    logic at_data;
    logic index_wr;

    // Address match for the two ports.
    always_comb begin
        at_index = (io_addr == INDEX_ADDR);
        at_data  = (io_addr == DATA_ADDR);
    end

    // Qualified strobes; all gated by the window enable.
    always_comb begin
        index_wr = win_en && io_wr && at_index;
        data_wr  = win_en && io_wr && at_data;
        rd_hit   = win_en && io_rd && (at_index || at_data);
    end

    // Current index register; loaded only by index-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= '0;
        end else if (index_wr) begin
            cur_idx <= io_wdata[cfgw_pkg::IDX_W-1:0];
        end
    end

endmodule

// File: rtl/cfgw_write_filter.sv
// Module cfgw_write_filter
// Combinational write permission for a data-port write: the index must be
// open for writing, and a value-locked index also needs its one exact value.
module cfgw_write_filter (
    input  logic [cfgw_pkg::IDX_W-1:0]  idx,
    input  logic [cfgw_pkg::BYTE_W-1:0] data,
    output logic                        allow
);
    import cfgw_pkg::*;

    logic open_ok;
    logic lock_ok;

    // Index-level permission.
    always_comb open_ok = idx_open(idx);

    // Value check for locked indices; unlocked indices pass.
    always_comb lock_ok = !idx_locked(idx) || (data == lock_value(idx));

    // Combined permission.
    always_comb allow = open_ok && lock_ok;

endmodule

// File: rtl/cfgw_reg_bank.sv
// Module cfgw_reg_bank
// The 256-byte register store with per-index reset defaults, one write
// port and one combinational read port. Assumes the caller has already
// filtered the write enable.
module cfgw_reg_bank (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [cfgw_pkg::IDX_W-1:0]  widx,
    input  logic [cfgw_pkg::BYTE_W-1:0] wdata,
    input  logic [cfgw_pkg::IDX_W-1:0]  ridx,
    output logic [cfgw_pkg::BYTE_W-1:0] rdata
);
    import cfgw_pkg::*;

    byte_t regs [NUM_REGS];

    // Load defaults on reset, else apply the single permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= reset_byte(idx_t'(i));
            end
        end else if (we) begin
            regs[widx] <= wdata;
        end
    end

    // Read the selected byte.
    always_comb rdata = regs[ridx];

endmodule

// File: rtl/cfg_window.sv
// Module cfg_window
// Two-port indexed configuration window: index port at IO_BASE, data port
// at IO_BASE+1, 256 byte registers with per-index write filtering, the
// whole window gated by a bit of an external bridge configuration byte.
// Assumes single-byte accesses and at most one access per cycle.
module cfg_window #(
    parameter int          ADDR_W        = 16,
    parameter logic [15:0] IO_BASE       = 16'h03F0,
    parameter int          BR_OFS_W      = 8,
    parameter logic [7:0]  BR_EN_OFS     = 8'h85,
    parameter int          BR_EN_BIT     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bridge_wr_en,
    input  logic [BR_OFS_W-1:0]  bridge_wr_addr,
    input  logic [7:0]           bridge_wr_data,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata
);
    import cfgw_pkg::*;

    localparam byte_t IDLE_BYTE = {BYTE_W{1'b1}};

    logic  win_en;
    idx_t  cur_idx;
    logic  data_wr;
    logic  rd_hit;
    logic  allow;
    logic  bank_we;
    byte_t sel_byte;

    cfgw_enable_gate #(
        .OFS_W  (BR_OFS_W),
        .EN_OFS (BR_EN_OFS),
        .EN_BIT (BR_EN_BIT)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bridge_wr_en),
        .wr_addr (bridge_wr_addr),
        .wr_data (bridge_wr_data),
        .win_en  (win_en)
    );

    cfgw_port_decode #(
        .ADDR_W  (ADDR_W),
        .IO_BASE (IO_BASE)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_en   (win_en),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .cur_idx  (cur_idx),
        .data_wr  (data_wr),
        .rd_hit   (rd_hit)
    );

    cfgw_write_filter u_filter (
        .idx   (cur_idx),
        .data  (io_wdata),
        .allow (allow)
    );

    // Only permitted data-port writes reach the store.
    always_comb bank_we = data_wr && allow;

    cfgw_reg_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .widx  (cur_idx),
        .wdata (io_wdata),
        .ridx  (cur_idx),
        .rdata (sel_byte)
    );

    // Drive read data; all ones when no decoded read is in progress.
    always_comb io_rdata = rd_hit ? sel_byte : IDLE_BYTE;

endmodule

// File: rtl/cfgw_checker.sv
// Module cfgw_checker
// Cycle-level properties of cfg_window, attached by bind. Observes the
// ports plus the window enable, current index and selected byte.
module cfgw_checker #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] IO_BASE   = 16'h03F0,
    parameter int          BR_OFS_W  = 8,
    parameter logic [7:0]  BR_EN_OFS = 8'h85,
    parameter int          BR_EN_BIT = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bridge_wr_en,
    input logic [BR_OFS_W-1:0] bridge_wr_addr,
    input logic [7:0]          bridge_wr_data,
    input logic                io_wr,
    input logic                io_rd,
    input logic [ADDR_W-1:0]   io_addr,
    input logic [7:0]          io_wdata,
    input logic [7:0]          io_rdata,
    input logic                win_en,
    input logic [7:0]          cur_idx,
    input logic [7:0]          sel_byte
);
    localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(IO_BASE) + ADDR_W'(1);

    logic ro_idx;
    logic dat_wr_now;

    // Independent read-only map for the checks.
    always_comb begin
        ro_idx = (cur_idx <= 8'hDF) || (cur_idx == 8'hE4) || (cur_idx == 8'hE5)
              || (cur_idx >= 8'hE9 && cur_idx <= 8'hED) || (cur_idx == 8'hF3)
              || (cur_idx == 8'hF5) || (cur_idx == 8'hF7)
              || (cur_idx >= 8'hF9 && cur_idx <= 8'hFB) || (cur_idx >= 8'hFD);
        dat_wr_now = win_en && io_wr && (io_addr == A_DAT);
    end

    AST_CLOSED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> io_rdata == 8'hFF); // R8

    AST_CLOSED_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |=> $stable(cur_idx)); // R8

    AST_INDEX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && io_wr && io_addr == A_IDX) |=> cur_idx == $past(io_wdata)); // R3

    AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && !bridge_wr_en) |=> ($stable(cur_idx) && $stable(sel_byte))); // R7

    AST_READONLY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_now && ro_idx) |=> $stable(sel_byte)); // R5

    AST_LOCK_E7_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_now && cur_idx == 8'hE7 && io_wdata != 8'hFE) |=> $stable(sel_byte)); // R6

    AST_LOCK_E8_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_now && cur_idx == 8'hE8 && io_wdata != 8'hBE) |=> $stable(sel_byte)); // R6

    AST_ENABLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_wr_en && bridge_wr_addr == BR_OFS_W'(BR_EN_OFS))
        |=> win_en == $past(bridge_wr_data[BR_EN_BIT])); // R2

    AST_OFF_PORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != A_IDX && io_addr != A_DAT) |-> io_rdata == 8'hFF); // R10

endmodule

bind cfg_window cfgw_checker #(
    .ADDR_W    (ADDR_W),
    .IO_BASE   (IO_BASE),
    .BR_OFS_W  (BR_OFS_W),
    .BR_EN_OFS (BR_EN_OFS),
    .BR_EN_BIT (BR_EN_BIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bridge_wr_en   (bridge_wr_en),
    .bridge_wr_addr (bridge_wr_addr),
    .bridge_wr_data (bridge_wr_data),
    .io_wr          (io_wr),
    .io_rd          (io_rd),
    .io_addr        (io_addr),
    .io_wdata       (io_wdata),
    .io_rdata       (io_rdata),
    .win_en         (win_en),
    .cur_idx        (cur_idx),
    .sel_byte       (sel_byte)
);

// File: tb/cfg_window_bench.sv
// Directed bench for cfg_window: one task per scenario, each checking its
// own results against values taken from the requirements.
module cfg_window_bench;

    localparam logic [15:0] P_IDX = 16'h03F0;
    localparam logic [15:0] P_DAT = 16'h03F1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bridge_wr_en = 1'b0;
    logic [7:0]  bridge_wr_addr = '0;
    logic [7:0]  bridge_wr_data = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfg_window u_cfg_window (
        .clk            (clk),
        .rst_n          (rst_n),
        .bridge_wr_en   (bridge_wr_en),
        .bridge_wr_addr (bridge_wr_addr),
        .bridge_wr_data (bridge_wr_data),
        .io_wr          (io_wr),
        .io_rd          (io_rd),
        .io_addr        (io_addr),
        .io_wdata       (io_wdata),
        .io_rdata       (io_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bridge_write(input logic [7:0] ofs, input logic [7:0] data);
        @(negedge clk);
        bridge_wr_en = 1'b1; bridge_wr_addr = ofs; bridge_wr_data = data;
        @(negedge clk);
        bridge_wr_en = 1'b0;
    endtask

    task automatic io_write(input logic [15:0] addr, input logic [7:0] data);
        @(negedge clk);
        io_wr = 1'b1; io_addr = addr; io_wdata = data;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] addr, output logic [7:0] data);
        @(negedge clk);
        io_rd = 1'b1; io_addr = addr;
        #1 data = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic sel_read(input logic [7:0] idx, output logic [7:0] data);
        io_write(P_IDX, idx);
        io_read(P_DAT, data);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        #1 check("R10 idle rdata", io_rdata, 8'hFF);
        io_read(P_DAT, d); check("R1 closed data read", d, 8'hFF);
        io_read(P_IDX, d); check("R1 closed index read", d, 8'hFF);
    endtask

    task automatic t_enable_control();
        logic [7:0] d;
        bridge_write(8'h84, 8'hFF);
        io_read(P_DAT, d); check("R2 other offset ignored", d, 8'hFF);
        bridge_write(8'h85, 8'hFD);
        io_read(P_DAT, d); check("R2 bit1 clear keeps closed", d, 8'hFF);
        bridge_write(8'h85, 8'h02);
        io_read(P_DAT, d); check("R1 index zero after reset", d, 8'h00);
    endtask

    task automatic t_defaults();
        logic [7:0] d;
        sel_read(8'hE0, d); check("R9 E0", d, 8'h3C);
        sel_read(8'hE2, d); check("R9 E2", d, 8'h03);
        sel_read(8'hE3, d); check("R9 E3", d, 8'hFC);
        sel_read(8'hE6, d); check("R9 E6", d, 8'hDE);
        sel_read(8'hE7, d); check("R9 E7", d, 8'hFE);
        sel_read(8'hE8, d); check("R9 E8", d, 8'hBE);
        sel_read(8'hE1, d); check("R9 E1", d, 8'h00);
        sel_read(8'hFF, d); check("R9 FF", d, 8'h00);
    endtask

    task automatic t_writable();
        logic [7:0] d;
        io_write(P_IDX, 8'hE2); io_write(P_DAT, 8'h5A);
        io_read(P_DAT, d); check("R4 E2 store", d, 8'h5A);
        io_read(P_IDX, d); check("R4 read at index port", d, 8'h5A);
        io_write(P_IDX, 8'hEE); io_write(P_DAT, 8'h11);
        io_read(P_DAT, d); check("R4 EE store", d, 8'h11);
        io_write(P_IDX, 8'hFC); io_write(P_DAT, 8'hA5);
        io_read(P_DAT, d); check("R4 FC store", d, 8'hA5);
        sel_read(8'hE6, d); check("R3 index selects E6", d, 8'hDE);
    endtask

    task automatic t_readonly();
        logic [7:0] d;
        logic [7:0] ro [7] = '{8'h00, 8'h10, 8'hDF, 8'hE4, 8'hE9, 8'hF3, 8'hFD};
        foreach (ro[i]) begin
            io_write(P_IDX, ro[i]); io_write(P_DAT, 8'h77);
            io_read(P_DAT, d); check("R5 read-only index kept", d, 8'h00);
        end
    endtask

    task automatic t_locked();
        logic [7:0] d;
        io_write(P_IDX, 8'hE7); io_write(P_DAT, 8'h12);
        io_read(P_DAT, d); check("R6 E7 bad value dropped", d, 8'hFE);
        io_write(P_DAT, 8'hFE);
        io_read(P_DAT, d); check("R6 E7 good value", d, 8'hFE);
        io_write(P_IDX, 8'hE8); io_write(P_DAT, 8'h00);
        io_read(P_DAT, d); check("R6 E8 bad value dropped", d, 8'hBE);
        io_write(P_DAT, 8'hFE);
        io_read(P_DAT, d); check("R6 E8 wrong lock value", d, 8'hBE);
    endtask

    task automatic t_sticky_index();
        logic [7:0] d;
        io_write(P_IDX, 8'hF0);
        io_write(P_DAT, 8'h21);
        io_read(P_DAT, d); check("R7 first read", d, 8'h21);
        io_read(P_DAT, d); check("R7 repeat read", d, 8'h21);
        io_write(P_DAT, 8'h42);
        io_read(P_DAT, d); check("R7 second write same index", d, 8'h42);
    endtask

    task automatic t_closed_ignore();
        logic [7:0] d;
        bridge_write(8'h85, 8'h00);
        io_write(P_IDX, 8'hE0);
        io_write(P_DAT, 8'h99);
        io_read(P_DAT, d); check("R8 closed read", d, 8'hFF);
        bridge_write(8'h85, 8'h02);
        io_read(P_DAT, d); check("R8 index and byte kept", d, 8'h42);
        sel_read(8'hE0, d); check("R8 E0 untouched", d, 8'h3C);
    endtask

    task automatic t_other_ports();
        logic [7:0] d;
        io_write(P_IDX, 8'hE3);
        io_write(16'h03F2, 8'h01);
        io_write(16'h02F1, 8'h02);
        io_write(16'h03F0 ^ 16'h0100, 8'hE2);
        io_read(16'h03F2, d); check("R10 off-window read", d, 8'hFF);
        io_read(P_DAT, d); check("R10 off-window writes ignored", d, 8'hFC);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset_state();
        t_enable_control();
        t_defaults();
        t_writable();
        t_readonly();
        t_locked();
        t_sticky_index();
        t_closed_ignore();
        t_other_ports();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule